// File: doc/BRIEF.md
# Disk Read Byte Assembler with Hold Window

This block turns the stream of recovered read bits coming off a floppy drive into bytes that a slow host can fetch by polling. A separate data separator marks each bit cell with a single-cycle strobe and supplies the bit value. Every strobe moves the value into the low end of an 8-bit assembly register, and older bits move toward the top. Every valid disk byte starts with a 1 bit, so a byte is complete as soon as the top bit of the register becomes 1. The register then stops changing for a hold window, which gives the host time to see and take the byte. When the window ends, the top bit drops back to 0 and the host can find the next byte boundary.

All timing runs from the fast clock. The default timed mode holds the byte for two bit cells plus four clocks. A legacy mode, for older polling loops, keeps the byte visible until the first two bits of the next byte have arrived. Bits that arrive during the hold are not lost. A small side register collects them, and they are loaded into the low end of the main register when the hold ends.

Top module: `disk_read_shifter`

## Requirements
- R1: While `rst_n` is low, `dout` reads 0. While the internal synchronized reset is still active after release, strobes are ignored.
- R2: When not holding, each cycle with `bit_stb` = 1 shifts `dout` left by one place and puts `bit_val` in bit 0. The change is visible after that clock edge.
- R3: A byte is complete when `dout[7]` becomes 1. From that point until the hold ends, `dout` does not change, whatever happens on `bit_stb`.
- R4: With `mode_legacy` = 0, `dout[7]` stays 1 for exactly 2*CELL_CYC+4 clock cycles, counted from the strobe edge that completed the byte. With the defaults this is 36 cycles.
- R5: With `mode_legacy` = 0, when the hold ends, `dout` is loaded with the bits strobed during the hold. They are packed at the low end in arrival order, with the newest in bit 0, and the upper bits are 0.
- R6: With `mode_legacy` = 1, the hold ends on the clock edge of the second strobe after completion. `dout` then becomes {6'b0, first, second}.
- R7: With `mode_legacy` = 1, the hold has no time limit. The byte stays on `dout` for as long as fewer than two strobes have arrived.
- R8: Between bytes, `dout[7]` reads 0. It drops at the end of every hold, before the next byte can complete.
- R9: `bit_val` has no effect on `dout` in cycles without `bit_stb`.
- R10: The side register keeps only the last SIDE_W bits (3 by default) strobed during a hold. The earlier ones are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all read timing derives from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_legacy | input | 1 | 0: timed hold of two cells plus four clocks; 1: hold until two new bits arrive |
| bit_stb | input | 1 | One-cycle strobe per received bit cell |
| bit_val | input | 1 | Recovered bit value, sampled when `bit_stb` is 1 |
| dout | output | DATA_W (8) | Assembly register as seen by the polling host |

## Verification
The bench goes after the hold length in both modes:
- A timer that is off by one clock, or that counts from the wrong edge, gives a hold of 35 or 37 cycles instead of 36.
- A legacy release that waits for only one bit, or that times out, gives a hold other than 32 cycles, or shows the byte disappearing during a long idle gap.

The bench also checks the value loaded at release:
- A design that clears to zero loses the first bits of the next byte.
- A design that keeps the oldest side bits instead of the newest gives a value other than 3 after four fast strobes.

A stall that bit_val toggling without strobes disturbs would show up as a changed partial byte. Back-to-back bytes check that bit 7 falls between every pair of bytes.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic {
    ST_SHIFT = 1'b0,
    ST_HOLD  = 1'b1
  } drs_state_e;
endpackage

// File: rtl/drs_rst_sync.sv
module drs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/drs_hold_timer.sv
module drs_hold_timer #(
  parameter int HOLD_CYC = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/drs_side_reg.sv
module drs_side_reg #(
  parameter int SIDE_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           shift,
  input  logic                           bit_in,
  output logic [SIDE_W-1:0]              bits_nxt,
  output logic [$clog2(SIDE_W+1)-1:0]    cnt_nxt
);
  localparam int SCNT_W = $clog2(SIDE_W + 1);

  logic [SIDE_W-1:0] bits_q;
  logic [SCNT_W-1:0] cnt_q;

  always_comb begin
    bits_nxt = bits_q;
    cnt_nxt  = cnt_q;
    if (shift) begin
      bits_nxt = {bits_q[SIDE_W-2:0], bit_in};
      if (cnt_q != SCNT_W'(SIDE_W)) cnt_nxt = cnt_q + SCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_nxt;
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/disk_read_shifter.sv
module disk_read_shifter
  import drs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CELL_CYC = 16,
  parameter int SIDE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_legacy,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [DATA_W-1:0] dout
);
  localparam int HOLD_CYC = 2 * CELL_CYC + 4;
  localparam int SCNT_W   = $clog2(SIDE_W + 1);

  logic              rst_n_i;
  drs_state_e        state_q, state_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              tmr_load, tmr_last;
  logic              side_shift, side_clr;
  logic [SIDE_W-1:0] side_bits_nxt;
  logic [SCNT_W-1:0] side_cnt_nxt;
  logic              release_now;
  logic              hold_q;

  drs_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  drs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (tmr_load),
    .last  (tmr_last)
  );

  drs_side_reg #(.SIDE_W(SIDE_W)) u_side (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (side_clr),
    .shift    (side_shift),
    .bit_in   (bit_val),
    .bits_nxt (side_bits_nxt),
    .cnt_nxt  (side_cnt_nxt)
  );

  assign hold_q = (state_q == ST_HOLD);

  always_comb begin
    state_d     = state_q;
    sr_d        = sr_q;
    tmr_load    = 1'b0;
    side_shift  = 1'b0;
    side_clr    = 1'b0;
    release_now = 1'b0;
    case (state_q)
      ST_SHIFT: begin
        if (bit_stb) begin
          sr_d = {sr_q[DATA_W-2:0], bit_val};
          if (sr_q[DATA_W-2]) begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        side_shift  = bit_stb;
        release_now = mode_legacy ? (side_cnt_nxt >= SCNT_W'(2)) : tmr_last;
        if (release_now) begin
          sr_d     = {{(DATA_W-SIDE_W){1'b0}}, side_bits_nxt};
          state_d  = ST_SHIFT;
          side_clr = 1'b1;
        end
      end
      default: state_d = ST_SHIFT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_SHIFT;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
    end
  end

  assign dout = sr_q;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int DATA_W   = 8,
  parameter int CELL_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ni,
  input logic              mode_legacy,
  input logic              bit_stb,
  input logic              hold_q,
  input logic [DATA_W-1:0] dout
);
  localparam int HOLD_CYC = 2 * CELL_CYC + 4;
  localparam int RUN_W    = $clog2(HOLD_CYC + 2) + 1;

  logic [RUN_W-1:0] run_cnt;
  logic [1:0]       stb_cnt;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
      stb_cnt <= '0;
    end else begin
      if (dout[DATA_W-1] && !mode_legacy) begin
        if (run_cnt != '1) run_cnt <= run_cnt + RUN_W'(1);
      end else begin
        run_cnt <= '0;
      end
      if (!hold_q)                        stb_cnt <= '0;
      else if (bit_stb && stb_cnt != 2'd3) stb_cnt <= stb_cnt + 2'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> dout == '0); // R1

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_ni)
    (!hold_q && bit_stb) |=> dout[DATA_W-1:1] == $past(dout[DATA_W-2:0])); // R2

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (hold_q && $past(hold_q)) |-> $stable(dout)); // R3

  AST_TOP_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(dout[DATA_W-1]) |-> hold_q); // R3

  AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    !mode_legacy |-> run_cnt <= RUN_W'(HOLD_CYC)); // R4

  AST_LEGACY_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_legacy && hold_q && bit_stb && stb_cnt >= 2'd1) |=> !dout[DATA_W-1]); // R6
endmodule

bind disk_read_shifter drs_checker #(.DATA_W(DATA_W), .CELL_CYC(CELL_CYC)) u_drs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_ni      (rst_n_i),
  .mode_legacy (mode_legacy),
  .bit_stb     (bit_stb),
  .hold_q      (hold_q),
  .dout        (dout)
);

// File: tb/disk_read_shifter_bench.sv
module disk_read_shifter_bench;
  localparam int CELL = 16;
  localparam int HOLD = 2 * CELL + 4;
  localparam int LEG  = 2 * CELL;

  typedef struct {
    logic [7:0] b;
    int         hold;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_legacy;
  logic       bit_stb;
  logic       bit_val;
  logic [7:0] dout;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  disk_read_shifter #(.DATA_W(8), .CELL_CYC(CELL), .SIDE_W(3)) u_disk_read_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_legacy (mode_legacy),
    .bit_stb     (bit_stb),
    .bit_val     (bit_val),
    .dout        (dout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic send_bit_gap(input logic v, input int gap);
    repeat (gap - 1) @(negedge clk);
    bit_stb = 1'b1;
    bit_val = v;
    @(negedge clk);
    bit_stb = 1'b0;
    bit_val = ~v;
  endtask

  task automatic send_bit(input logic v);
    send_bit_gap(v, CELL);
  endtask

  task automatic send_part(input logic [7:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold);
    item_t it;
    it.b = b;
    it.hold = hold;
    exp_q.push_back(it);
    send_part(b, 7, 0);
  endtask

  // monitor: pops an expected byte on each rise of bit 7, checks hold length at the fall
  item_t      cur;
  logic       prev7;
  int         run;
  logic [7:0] lastv;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev7 = 1'b0;
      run   = 0;
    end else begin
      if (dout[7] && !prev7) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected byte", int'(dout), 0);
        end else begin
          cur = exp_q.pop_front();
          check(dout == cur.b, "R3 byte value at completion", int'(dout), int'(cur.b));
        end
        run = 1;
      end else if (dout[7]) begin
        run++;
      end else if (prev7) begin
        check(lastv == cur.b, "R3 byte frozen through hold", int'(lastv), int'(cur.b));
        check(run == cur.hold, "R4 R6 R8 hold length", run, cur.hold);
      end
      lastv = dout;
      prev7 = dout[7];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    item_t it;
    rst_n = 1'b0; mode_legacy = 1'b0; bit_stb = 1'b0; bit_val = 1'b0;
    repeat (5) @(negedge clk);
    check(dout == 8'h00, "R1 reset value", int'(dout), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // first byte 0xB6, sent in pieces to look at partial contents
    it.b = 8'hB6; it.hold = HOLD; exp_q.push_back(it);
    send_part(8'hB6, 7, 5);
    check(dout == 8'h05, "R2 partial shift", int'(dout), 5);
    send_part(8'hB6, 4, 3);
    for (int i = 0; i < 20; i++) begin
      bit_val = ~bit_val;
      @(negedge clk);
    end
    check(dout == 8'h16, "R9 bit_val without strobe ignored", int'(dout), 8'h16);
    send_part(8'hB6, 2, 0);

    // default mode: bits during hold survive the release
    it.b = 8'hD5; it.hold = HOLD; exp_q.push_back(it);
    send_part(8'hD5, 7, 6);
    repeat (4) @(negedge clk);
    check(dout == 8'h03, "R5 R8 side bits loaded at release", int'(dout), 3);
    send_part(8'hD5, 5, 0);
    send_byte(8'hAA, HOLD);
    send_byte(8'h96, HOLD);
    send_byte(8'hFF, HOLD);
    repeat (HOLD + 4) @(negedge clk);
    check(dout == 8'h00, "R8 idle after final release", int'(dout), 0);

    // legacy mode
    mode_legacy = 1'b1;
    repeat (3) @(negedge clk);
    send_byte(8'hD5, LEG);
    it.b = 8'hE7; it.hold = 100 + 2 * CELL; exp_q.push_back(it);
    send_part(8'hE7, 7, 6);
    check(dout == 8'h03, "R6 legacy release after two bits", int'(dout), 3);
    send_part(8'hE7, 5, 0);
    repeat (100) @(negedge clk);
    check(dout == 8'hE7, "R7 legacy hold has no time limit", int'(dout), 8'hE7);
    send_byte(8'hAB, LEG);
    send_bit(1'b1);
    send_bit(1'b0);
    @(negedge clk);
    check(dout == 8'h02, "R6 legacy release value", int'(dout), 2);
    mode_legacy = 1'b0;

    // reset mid-stream, then side register saturation
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dout == 8'h00, "R1 reset mid-stream", int'(dout), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(8'hC3, HOLD);
    send_bit_gap(1'b1, 8);
    send_bit_gap(1'b0, 8);
    send_bit_gap(1'b1, 8);
    send_bit_gap(1'b1, 8);
    repeat (4) @(negedge clk);
    check(dout == 8'h03, "R10 side keeps newest three bits", int'(dout), 3);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule